// File: doc/BRIEF.md
# Prescaled PWM Generator

This block drives one pulse-width modulated output from a single 32-bit control word. The input clock first passes through a programmable divider. The divider's step pulse then advances a free-running 8-bit period counter, so one output period always lasts 256 steps. The output is high while the period counter is below the programmed duty value. A separate override bit holds the output high for the whole period.

Software writes the control word through a write-enable, address and data port and can read it back over the same port. Any write to the control word takes effect on the next clock edge. It restarts the divider and the period counter, so a period that is in progress is dropped rather than finished. Clearing the enable bit forces the output low at once.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset the output is 0 and the control word reads back as 0x0000_0000.
- R2: The control word has this layout: bit 31 is enable, bit 24 is the full-duty override, bits [23:16] hold the duty value and bits [12:0] hold the scale value. Every other bit is discarded on write and reads back as 0.
- R3: The period counter advances once every scale+1 input clocks. One output period is therefore 256 × (scale+1) clocks, and the pattern repeats after the counter wraps.
- R4: While enabled and without override, the output is high for the first duty × (scale+1) clocks of each period and low for the rest.
- R5: With a duty value of 0 and no override, the output stays low for the whole period.
- R6: While enabled with bit 24 set, the output is high in every cycle, whatever the duty value.
- R7: A write that clears the enable bit makes the output 0 from the next cycle on. The output stays 0 while the block is disabled.
- R8: A write to the control word restarts the divider and the period counter from zero. The new period begins in the cycle after the write, even if the previous period was not finished.
- R9: The control word sits at address 0. A write to any other address changes neither the stored word nor the output, and a read from any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench writes a set of control words and counts the high cycles over exactly one period. It then checks the level on both sides of the period boundary. The words cover:
- scale values from 0 to 3, which separate a correct divide ratio from an off-by-one;
- duty values of 0, 1, half scale and 255, which expose errors in the comparison at its edges;
- the override bit with several duty values, which shows the override dominates the comparison;
- stray reserved bits, which shows they are ignored.

Directed cases cover the following:
- disabling in the middle of a high phase;
- rewriting the same word after the high phase, which shows the period restarts;
- writes and reads at a foreign address;
- the masked read-back of an all-ones write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SCALE_W  = 13;
  localparam int unsigned DUTY_W   = 8;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned FULL_BIT = 24;
  localparam int unsigned DUTY_LSB = 16;
  localparam int unsigned SCALE_LSB = 0;

  typedef struct packed {
    logic               en;
    logic               full;
    logic [DUTY_W-1:0]  duty;
    logic [SCALE_W-1:0] scale;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
  import pwm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output pwm_cfg_t          cfg_o,
  output logic              restart_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  pwm_cfg_t cfg_q;
  logic     hit;

  assign hit       = (addr_i == HIT_ADDR);
  assign restart_o = we_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (restart_o) begin
      cfg_q.en    <= wdata_i[EN_BIT];
      cfg_q.full  <= wdata_i[FULL_BIT];
      cfg_q.duty  <= wdata_i[DUTY_LSB +: DUTY_W];
      cfg_q.scale <= wdata_i[SCALE_LSB +: SCALE_W];
    end
  end

  logic [DATA_W-1:0] word;
  always_comb begin
    word                          = '0;
    word[EN_BIT]                  = cfg_q.en;
    word[FULL_BIT]                = cfg_q.full;
    word[DUTY_LSB +: DUTY_W]      = cfg_q.duty;
    word[SCALE_LSB +: SCALE_W]    = cfg_q.scale;
  end

  assign rdata_o = hit ? word : '0;
  assign cfg_o   = cfg_q;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[30:25], wdata_i[15:13]};

  assert_foreign_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable(cfg_q));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SCALE_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               restart_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               step_o
);
  logic [SCALE_W-1:0] cnt_q;

  assign step_o = en_i && (cnt_q == scale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !en_i) cnt_q <= '0;
    else if (step_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assert_pre_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= scale_i));
  assert_pre_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == '0));
  assert_pre_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic              step_i,
  input  logic              full_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pos_q <= '0;
    else if (restart_i || !en_i) pos_q <= '0;
    else if (step_i)             pos_q <= pos_q + 1'b1;
  end

  // inactive level is 0
  assign pwm_o = en_i && (full_i || (pos_q < duty_i));

  assert_pos_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && en_i) |=> (pos_q == $past(pos_q) + 1'b1));
  assert_pos_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i && en_i) |=> $stable(pos_q));
  assert_pos_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pos_q == '0));
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  pwm_cfg_t cfg;
  logic     restart;
  logic     step;

  pwm_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cfg_o(cfg), .restart_o(restart)
  );

  pwm_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk_i, .rst_ni, .en_i(cfg.en), .restart_i(restart),
    .scale_i(cfg.scale), .step_o(step)
  );

  pwm_period #(.DUTY_W(DUTY_W)) u_per (
    .clk_i, .rst_ni, .en_i(cfg.en), .restart_i(restart), .step_i(step),
    .full_i(cfg.full), .duty_i(cfg.duty), .pwm_o
  );

  assert_off_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.en |-> !pwm_o);
  assert_full_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.en && cfg.full) |-> pwm_o);
  assert_disable_now_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !wdata_i[EN_BIT]) |=> !pwm_o);
endmodule

// File: tb/sim_pwm_prescaled.sv
module sim_pwm_prescaled;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwm_prescaled u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // {control word, expected high cycles per period}
  localparam logic [47:0] VEC [8] = '{
    {32'h8080_0000, 16'd128},
    {32'h8040_0001, 16'd128},
    {32'h8001_0002, 16'd3},
    {32'h80FF_0003, 16'd1020},
    {32'h8000_0000, 16'd0},
    {32'h8100_0001, 16'd512},
    {32'h814D_0000, 16'd256},
    {32'h8080_E000, 16'd128}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0;
  endtask

  task automatic run_period(input logic [31:0] w, input int exp_hi, input string req);
    int p = 256 * (int'(w[12:0]) + 1);
    int hi = 0;
    logic first;
    wr(2'd0, w);
    first = pwm;
    for (int k = 0; k < p; k++) begin
      if (pwm) hi++;
      if (k < p - 1) @(negedge clk);
    end
    check(req, hi, exp_hi);
    if (exp_hi > 0 && exp_hi < p) check("R3 last step low", {31'd0, pwm}, 32'd0);
    @(negedge clk);
    check("R3 wrap repeats", {31'd0, pwm}, {31'd0, first});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check("R1 reset pwm", {31'd0, pwm}, 32'd0);
    check("R1 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R3 R2 vector walk
    for (int i = 0; i < 8; i++)
      run_period(VEC[i][47:16], int'(VEC[i][15:0]), "R4 high count");

    // R2 masked readback
    wr(2'd0, 32'hFFFF_FFFF);
    check("R2 readback", rdata, 32'h81FF_1FFF);

    // R7 disable mid high phase
    wr(2'd0, 32'h80FF_0000);
    repeat (10) @(negedge clk);
    check("R7 running high", {31'd0, pwm}, 32'd1);
    wr(2'd0, 32'h01FF_0000);
    check("R7 low next cycle", {31'd0, pwm}, 32'd0);
    hi = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    check("R7 stays low", hi, 0);

    // R8 restart after high phase
    wr(2'd0, 32'h800A_0003);
    repeat (100) @(negedge clk);
    check("R8 low before rewrite", {31'd0, pwm}, 32'd0);
    run_period(32'h800A_0003, 40, "R8 restart high count");

    // R9 foreign address
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'h8100_0000);
    check("R9 output unchanged", {31'd0, pwm}, 32'd0);
    addr = 2'd1;
    #1;
    check("R9 foreign read", rdata, 32'h0);
    addr = 2'd0;
    #1;
    check("R9 word unchanged", rdata, 32'h8000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule